// File: doc/BRIEF.md
# Overlay Character Memory Serial Front End

This block is the serial register front end of a character-overlay display memory. The memory has 480 entries, and each entry pairs an 8-bit character code with an 8-bit attribute. A host drives a mode-0 SPI link. Every access is an address byte followed by a data byte. Through these accesses the host moves a 9-bit memory pointer, picks a write mode and stores characters. It can also read registers and memory bytes back, or start a self-timed wipe of the whole memory. A renderer reads entries through a separate combinational port.

The SPI pins are sampled with the system clock. Each pin passes through a two-stage synchronizer, and a shifter turns the SCLK edges into byte events. Three states track the link: `S_ADDR` waits for an address byte, `S_WDATA` waits for the data byte of a write, and `S_RDATA` waits out the byte during which read data shifts out. A completed byte moves `S_ADDR` to `S_RDATA` when bit 7 of that byte is set and to `S_WDATA` when it is clear. The next completed byte returns either state to `S_ADDR`. Raising chip select returns the link to `S_ADDR` from any state. A separate clear engine has two states, `C_IDLE` and `C_RUN`. It leaves `C_IDLE` when a wipe is requested and returns after it has written the last entry. Reset places it in `C_RUN`, so the memory is wiped at power-up.

Register map, as seen in the low 7 bits of the address byte:
- 0x04 mode: bit 6 selects byte-wide mode, bits 5:3 hold the streamed attribute, bit 2 starts a wipe, bit 0 turns on streaming.
- 0x05 pointer high: bit 0 is pointer bit 8, bit 1 is the lane select.
- 0x06 pointer low: pointer bits 7:0.
- 0x07 data-in: write only.
- 0x30 data-out: read only, so it is reached with address byte 0xB0.

Top module: `osd_dmem_spi`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is sampled on rising SCLK and MISO changes after falling SCLK. Bit 7 of the address byte marks a read (1) or a write (0), and the data byte follows. During a read, the selected value shifts out on MISO during the byte that follows the address byte. MISO is 0 while chip select is high and after reset.
- R2: While chip select stays low, several address/data pairs may follow one another, and each pair is decoded on its own.
- R3: Writing 0x05 sets pointer bit 8 from data bit 0 and the lane select from data bit 1. Writing 0x06 sets pointer bits 7:0. Reading them back returns {6'b0, select, ptr[8]} and ptr[7:0].
- R4: In word mode (mode bit 6 = 0) with streaming off, a write to 0x07 stores entry = {5'b0, mode[5:3], data} at the pointer. The pointer is left unchanged.
- R5: In byte-wide mode (mode bit 6 = 1) with streaming off, a write to 0x07 replaces only the attribute byte (entry[15:8]) when the select bit is 1, and only the character byte (entry[7:0]) when it is 0.
- R6: With streaming on (mode bit 0 = 1), each write to 0x07 stores {5'b0, mode[5:3], data} at the pointer and then adds one to the pointer.
- R7: With streaming on, data 0xFF written to 0x07 is not stored and turns streaming off, so mode bit 0 reads back as 0. Later data-in writes follow R4/R5.
- R8: Streaming stores at entry 479 but does not move the pointer past it. Further streamed bytes are dropped until 0x05 or 0x06 is written.
- R9: A data-in write with the pointer at 480 or above changes no entry, and data-out then reads 0x00.
- R10: Setting mode bit 2 wipes every entry to 0x0000, one entry per clock, and keeps the engine busy for exactly 480 clocks. Mode bit 2 reads 1 while the wipe runs, and data-in writes made during the wipe are dropped. A wipe also runs right after reset.
- R11: Reading data-out (0xB0) returns the attribute byte of the entry at the pointer when byte-wide mode and select are both 1, and the character byte otherwise.
- R12: Writes to any address other than 0x04–0x07 change nothing. Reads of addresses other than 0x04, 0x05, 0x06 and 0x30 return 0x00. Reading the mode register returns {0, mode[6], mode[5:3], busy, 0, mode[0]}.
- R13: The renderer port returns the entry at its address combinationally, and 0x0000 for addresses of 480 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| rnd_addr | input | 9 | Renderer entry address |
| rnd_entry | output | 16 | Renderer entry: {attribute, character} |

## Verification
Directed sequences cover the corner cases. These are a single word write, then byte-lane writes to each half of the same entry, and then a stream chained inside one chip-select window that ends on 0xFF. Further sequences stream up to the final entry, write beyond the top of memory, write to unmapped addresses, and start a wipe while a data-in write is pending. Each of these patterns catches a different fault: a wrong lane or attribute merge, a pointer that advances when it should not, a terminator that is stored, a pointer that wraps, or a wipe that is too short or lets writes through. After these, a seeded random mix of mode, pointer, data and stray accesses runs against a bench model. Reads are compared on MISO, and the whole memory is compared through the renderer port.

// File: rtl/osd_pkg.sv
package osd_pkg;

    typedef enum logic [1:0] {
        S_ADDR  = 2'd0,
        S_WDATA = 2'd1,
        S_RDATA = 2'd2
    } link_state_t;

    typedef enum logic {
        C_IDLE = 1'b0,
        C_RUN  = 1'b1
    } clr_state_t;

    localparam logic [6:0] REG_MODE = 7'h04;
    localparam logic [6:0] REG_AHI  = 7'h05;
    localparam logic [6:0] REG_ALO  = 7'h06;
    localparam logic [6:0] REG_DIN  = 7'h07;
    localparam logic [6:0] REG_DOUT = 7'h30;

    localparam logic [7:0] STREAM_END = 8'hFF;

endpackage

// File: rtl/osd_spi_shifter.sv
module osd_spi_shifter #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic       cs_active,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    input  logic       tx_load,
    input  logic [7:0] tx_byte
);

    localparam int unsigned LAST_STAGE = SYNC_STAGES - 1;

    // {sclk, cs_n, mosi} per stage
    logic [SYNC_STAGES-1:0][2:0] sync_q;
    logic                        sclk_d;
    logic [2:0]                  bit_cnt;
    logic [6:0]                  shift_in;
    logic [7:0]                  shift_out;
    logic                        sclk_s, mosi_s, rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{3'b010}};
            sclk_d <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], {sclk, cs_n, mosi}};
            sclk_d <= sclk_s;
        end
    end

    assign sclk_s    = sync_q[LAST_STAGE][2];
    assign cs_active = ~sync_q[LAST_STAGE][1];
    assign mosi_s    = sync_q[LAST_STAGE][0];
    assign rise      = cs_active & sclk_s & ~sclk_d;
    assign fall      = cs_active & ~sclk_s & sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shift_in   <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
            end else if (rise) begin
                bit_cnt  <= bit_cnt + 3'd1;
                shift_in <= {shift_in[5:0], mosi_s};
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {shift_in, mosi_s};
                end
            end
        end
    end

    // Transmit: loaded between bytes, shifted on falls inside a byte only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_out <= '0;
        end else if (!cs_active) begin
            shift_out <= '0;
        end else if (tx_load) begin
            shift_out <= tx_byte;
        end else if (fall && (bit_cnt != 3'd0)) begin
            shift_out <= {shift_out[6:0], 1'b0};
        end
    end

    assign miso = shift_out[7] & cs_active;

endmodule

// File: rtl/osd_clear_engine.sv
module osd_clear_engine
    import osd_pkg::*;
#(
    parameter int unsigned DEPTH = 480,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] idx
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    clr_state_t c_st, c_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_st <= C_RUN;
        else        c_st <= c_nx;
    end

    always_comb begin
        c_nx = c_st;
        unique case (c_st)
            C_IDLE:  if (start) c_nx = C_RUN;
            C_RUN:   if (idx == LAST_IDX) c_nx = C_IDLE;
            default: c_nx = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (c_st == C_RUN) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + {{(AW-1){1'b0}}, 1'b1};
        end
    end

    assign busy = (c_st == C_RUN);

endmodule

// File: rtl/osd_display_mem.sv
module osd_display_mem #(
    parameter int unsigned DEPTH = 480,
    parameter int unsigned AW    = 9,
    parameter int unsigned LANES = 2
) (
    input  logic               clk,
    input  logic [LANES-1:0]   we,
    input  logic [AW-1:0]      waddr,
    input  logic [8*LANES-1:0] wdata,
    input  logic [AW-1:0]      ra_addr,
    output logic [8*LANES-1:0] ra_data,
    input  logic [AW-1:0]      rb_addr,
    output logic [8*LANES-1:0] rb_data
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic w_ok, a_ok, b_ok;
    assign w_ok = (waddr   <= LAST_IDX);
    assign a_ok = (ra_addr <= LAST_IDX);
    assign b_ok = (rb_addr <= LAST_IDX);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we[b] && w_ok) lane[waddr] <= wdata[8*b +: 8];
        end

        assign ra_data[8*b +: 8] = a_ok ? lane[ra_addr] : 8'h00;
        assign rb_data[8*b +: 8] = b_ok ? lane[rb_addr] : 8'h00;
    end

endmodule

// File: rtl/osd_reg_ctrl.sv
module osd_reg_ctrl
    import osd_pkg::*;
#(
    parameter int unsigned DEPTH = 480,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_active,
    input  logic          byte_valid,
    input  logic [7:0]    rx_byte,
    input  logic          clr_busy,
    input  logic [15:0]   rd_entry,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic [1:0]    wr_en,
    output logic [AW-1:0] ptr,
    output logic [15:0]   wr_data,
    output logic          clr_start
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    link_state_t st, st_nx;
    logic [6:0]  reg_sel;
    logic        m_eight, m_ainc, sel_attr, full;
    logic [2:0]  m_attr;
    logic        wr_evt, din_evt, in_range, stream_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_ADDR;
        else        st <= st_nx;
    end

    // Next state and link outputs
    always_comb begin
        st_nx   = st;
        tx_load = 1'b0;
        wr_evt  = 1'b0;
        unique case (st)
            S_ADDR: begin
                if (byte_valid) begin
                    if (rx_byte[7]) begin
                        tx_load = 1'b1;
                        st_nx   = S_RDATA;
                    end else begin
                        st_nx = S_WDATA;
                    end
                end
            end
            S_WDATA: begin
                if (byte_valid) begin
                    wr_evt = 1'b1;
                    st_nx  = S_ADDR;
                end
            end
            S_RDATA: begin
                if (byte_valid) st_nx = S_ADDR;
            end
            default: st_nx = S_ADDR;
        endcase
        if (!cs_active) begin
            st_nx   = S_ADDR;
            tx_load = 1'b0;
            wr_evt  = 1'b0;
        end
    end

    assign in_range   = (ptr <= LAST_IDX);
    assign stream_end = (rx_byte == STREAM_END);
    assign din_evt    = wr_evt && (reg_sel == REG_DIN) && !clr_busy;
    assign clr_start  = wr_evt && (reg_sel == REG_MODE) && rx_byte[2];

    // Memory write request
    always_comb begin
        wr_en   = 2'b00;
        wr_data = {((m_eight && !m_ainc) ? rx_byte : {5'b0, m_attr}), rx_byte};
        if (din_evt) begin
            if (m_ainc) begin
                if (!stream_end && !full && in_range) wr_en = 2'b11;
            end else if (in_range) begin
                if (m_eight) wr_en = sel_attr ? 2'b10 : 2'b01;
                else         wr_en = 2'b11;
            end
        end
    end

    // Read value, selected by the address byte itself
    always_comb begin
        unique case (rx_byte[6:0])
            REG_MODE: tx_byte = {1'b0, m_eight, m_attr, clr_busy, 1'b0, m_ainc};
            REG_AHI:  tx_byte = {6'b0, sel_attr, ptr[8]};
            REG_ALO:  tx_byte = ptr[7:0];
            REG_DOUT: tx_byte = !in_range ? 8'h00 :
                                (m_eight && sel_attr) ? rd_entry[15:8] : rd_entry[7:0];
            default:  tx_byte = 8'h00;
        endcase
    end

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_sel  <= '0;
            m_eight  <= 1'b0;
            m_attr   <= '0;
            m_ainc   <= 1'b0;
            sel_attr <= 1'b0;
            full     <= 1'b0;
            ptr      <= '0;
        end else begin
            if (byte_valid && (st == S_ADDR) && cs_active) reg_sel <= rx_byte[6:0];
            if (wr_evt) begin
                unique case (reg_sel)
                    REG_MODE: begin
                        m_eight <= rx_byte[6];
                        m_attr  <= rx_byte[5:3];
                        m_ainc  <= rx_byte[0];
                    end
                    REG_AHI: begin
                        ptr      <= {rx_byte[AW-9:0], ptr[7:0]};
                        sel_attr <= rx_byte[1];
                        full     <= 1'b0;
                    end
                    REG_ALO: begin
                        ptr[7:0] <= rx_byte;
                        full     <= 1'b0;
                    end
                    REG_DIN: begin
                        if (din_evt && m_ainc) begin
                            if (stream_end) begin
                                m_ainc <= 1'b0;
                            end else if (!full && in_range) begin
                                if (ptr == LAST_IDX) full <= 1'b1;
                                else                 ptr  <= ptr + {{(AW-1){1'b0}}, 1'b1};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/osd_dmem_spi.sv
module osd_dmem_spi #(
    parameter int unsigned DEPTH = 480,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    input  logic [AW-1:0] rnd_addr,
    output logic [15:0]   rnd_entry
);

    logic          cs_active, byte_valid, tx_load, clr_start, clr_busy;
    logic [7:0]    rx_byte, tx_byte;
    logic [1:0]    ctl_we, mem_we;
    logic [AW-1:0] ctl_ptr, clr_idx, mem_waddr;
    logic [15:0]   ctl_wdata, mem_wdata, ptr_entry;

    osd_spi_shifter #(.SYNC_STAGES(2)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .cs_active  (cs_active),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte)
    );

    osd_reg_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .clr_busy   (clr_busy),
        .rd_entry   (ptr_entry),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .wr_en      (ctl_we),
        .ptr        (ctl_ptr),
        .wr_data    (ctl_wdata),
        .clr_start  (clr_start)
    );

    osd_clear_engine #(.DEPTH(DEPTH), .AW(AW)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .busy  (clr_busy),
        .idx   (clr_idx)
    );

    assign mem_we    = clr_busy ? 2'b11   : ctl_we;
    assign mem_waddr = clr_busy ? clr_idx : ctl_ptr;
    assign mem_wdata = clr_busy ? 16'h0   : ctl_wdata;

    osd_display_mem #(.DEPTH(DEPTH), .AW(AW), .LANES(2)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (ctl_ptr),
        .ra_data (ptr_entry),
        .rb_addr (rnd_addr),
        .rb_data (rnd_entry)
    );

endmodule

// File: rtl/osd_dmem_spi_chk.sv
module osd_dmem_spi_chk #(
    parameter int unsigned DEPTH = 480,
    parameter int unsigned AW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_valid,
    input logic          clr_busy,
    input logic [1:0]    mem_we,
    input logic [AW-1:0] mem_waddr
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [AW:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (clr_busy) busy_cnt <= busy_cnt + 1'b1;
        else               busy_cnt <= '0;
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 2'b00) |-> (mem_waddr <= LAST_IDX)); // R9

    AST_WR_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we != 2'b00) && !clr_busy) |-> byte_valid); // R4

    AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && $past(clr_busy) && $past(rst_n)) |-> (mem_waddr == $past(mem_waddr) + 1'b1)); // R10

    AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> (busy_cnt == (AW + 1)'(DEPTH))); // R10

    AST_BYTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R1

endmodule

bind osd_dmem_spi osd_dmem_spi_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .clr_busy   (clr_busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr)
);

// File: tb/osd_dmem_spi_tb_top.sv
module osd_dmem_spi_tb_top;

    localparam int DEPTH = 480;
    localparam int HALF  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [8:0]  rnd_addr = '0;
    logic [15:0] rnd_entry;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [15:0] bm_mem [DEPTH];
    logic        bm_eight = 0, bm_ainc = 0, bm_sel = 0, bm_full = 0, bm_busy = 1;
    logic [2:0]  bm_attr = 0;
    logic [8:0]  bm_ptr = 0;

    always #10 clk = ~clk;

    osd_dmem_spi dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .miso      (miso),
        .rnd_addr  (rnd_addr),
        .rnd_entry (rnd_entry)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- model ----------------
    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h04: begin
                bm_eight = d[6]; bm_attr = d[5:3]; bm_ainc = d[0];
                if (d[2] && !bm_busy) begin
                    for (int i = 0; i < DEPTH; i++) bm_mem[i] = 16'h0;
                    bm_busy = 1;
                end
            end
            8'h05: begin bm_ptr[8] = d[0]; bm_sel = d[1]; bm_full = 0; end
            8'h06: begin bm_ptr[7:0] = d; bm_full = 0; end
            8'h07: begin
                if (!bm_busy) begin
                    if (bm_ainc) begin
                        if (d == 8'hFF) bm_ainc = 0;
                        else if (!bm_full && bm_ptr < DEPTH) begin
                            bm_mem[bm_ptr] = {5'b0, bm_attr, d};
                            if (bm_ptr == DEPTH - 1) bm_full = 1;
                            else bm_ptr = bm_ptr + 1;
                        end
                    end else if (bm_ptr < DEPTH) begin
                        if (!bm_eight)   bm_mem[bm_ptr] = {5'b0, bm_attr, d};
                        else if (bm_sel) bm_mem[bm_ptr][15:8] = d;
                        else             bm_mem[bm_ptr][7:0] = d;
                    end
                end
            end
            default: ;
        endcase
    endtask

    function automatic logic [7:0] m_read(input logic [6:0] a);
        case (a)
            7'h04: return {1'b0, bm_eight, bm_attr, bm_busy, 1'b0, bm_ainc};
            7'h05: return {6'b0, bm_sel, bm_ptr[8]};
            7'h06: return bm_ptr[7:0];
            7'h30: begin
                if (bm_ptr >= DEPTH) return 8'h00;
                return (bm_eight && bm_sel) ? bm_mem[bm_ptr][15:8] : bm_mem[bm_ptr][7:0];
            end
            default: return 8'h00;
        endcase
    endfunction

    // ---------------- SPI master ----------------
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_open();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic pair_w(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer({1'b0, a[6:0]}, dummy);
        xfer(d, dummy);
        m_write({1'b0, a[6:0]}, d);
    endtask

    task automatic pair_r(input logic [6:0] a, input string tag);
        logic [7:0] dummy, v;
        xfer({1'b1, a}, dummy);
        xfer(8'hFF, v);
        check({8'h0, v}, {8'h0, m_read(a)}, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cs_open(); pair_w(a, d); cs_close();
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        cs_open(); pair_r(a, tag); cs_close();
    endtask

    task automatic chk_entry(input logic [8:0] a, input string tag);
        rnd_addr = a;
        @(negedge clk);
        check(rnd_entry, (a < DEPTH) ? bm_mem[a] : 16'h0, tag);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 512; i++) chk_entry(9'(i), tag);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < DEPTH; i++) bm_mem[i] = 16'h0;
        void'($urandom(32'd7741));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({15'b0, miso}, 16'h0, "R1 miso low after reset");

        // R10 power-up wipe in progress
        rd(7'h04, "R10 busy bit during power-up wipe");
        repeat (500) @(negedge clk);
        bm_busy = 0;
        rd(7'h04, "R12 mode readback after wipe");
        sweep("R10 memory zero after power-up wipe");

        // R4 / R11 word write
        wr(8'h04, 8'h28);
        wr(8'h05, 8'h00);
        wr(8'h06, 8'h05);
        wr(8'h07, 8'h41);
        chk_entry(9'd5, "R4 word write entry");
        rd(7'h30, "R11 data-out char byte");
        rd(7'h06, "R4 pointer unchanged");

        // R5 byte lanes
        wr(8'h04, 8'h40);
        wr(8'h05, 8'h02);
        wr(8'h07, 8'h9C);
        chk_entry(9'd5, "R5 attribute lane write");
        rd(7'h30, "R11 data-out attribute byte");
        rd(7'h05, "R3 high pointer readback");
        wr(8'h05, 8'h00);
        wr(8'h07, 8'h33);
        chk_entry(9'd5, "R5 character lane write");
        rd(7'h30, "R11 data-out char in byte mode");

        // R2 / R6 / R7 chained stream
        cs_open();
        pair_w(8'h05, 8'h01);
        pair_w(8'h06, 8'h10);
        pair_w(8'h04, 8'h19);
        pair_w(8'h07, 8'h11);
        pair_w(8'h07, 8'h12);
        pair_w(8'h07, 8'h13);
        pair_w(8'h07, 8'hFF);
        pair_r(7'h04, "R7 streaming bit cleared by 0xFF");
        pair_r(7'h06, "R6 pointer advanced by stream");
        cs_close();
        chk_entry(9'h110, "R6 streamed entry 0");
        chk_entry(9'h112, "R6 streamed entry 2");
        chk_entry(9'h113, "R7 terminator not stored");
        wr(8'h07, 8'h55);
        wr(8'h07, 8'h56);
        chk_entry(9'h113, "R7 single writes after stream end");
        rd(7'h06, "R7 pointer holds after stream end");

        // R8 end of memory
        wr(8'h05, 8'h01);
        wr(8'h06, 8'hDE);
        wr(8'h04, 8'h01);
        cs_open();
        pair_w(8'h07, 8'hA1);
        pair_w(8'h07, 8'hA2);
        pair_w(8'h07, 8'hA3);
        cs_close();
        chk_entry(9'd478, "R8 entry 478");
        chk_entry(9'd479, "R8 entry 479 keeps first byte");
        rd(7'h06, "R8 pointer stops at 479");
        wr(8'h06, 8'hDD);
        wr(8'h07, 8'hB4);
        chk_entry(9'd477, "R8 stream resumes after rewrite");
        wr(8'h07, 8'hFF);
        sweep("R8 memory after end-of-memory stream");

        // R9 out of range
        wr(8'h06, 8'hF0);
        wr(8'h07, 8'h77);
        rd(7'h30, "R9 data-out beyond range");
        chk_entry(9'd500, "R13 renderer beyond range");
        sweep("R9 no entry changed");

        // R12 unmapped
        wr(8'h0C, 8'h55);
        wr(8'h30, 8'h12);
        wr(8'h00, 8'hFF);
        rd(7'h0C, "R12 unmapped read");
        rd(7'h07, "R12 write-only read");
        rd(7'h04, "R12 mode unchanged");
        rd(7'h06, "R12 pointer unchanged");
        sweep("R12 memory unchanged");

        // R10 wipe by command
        wr(8'h05, 8'h00);
        wr(8'h06, 8'h05);
        wr(8'h04, 8'h04);
        wr(8'h07, 8'h5A);
        rd(7'h04, "R10 busy bit during wipe");
        repeat (600) @(negedge clk);
        bm_busy = 0;
        rd(7'h04, "R10 busy bit clears");
        sweep("R10 all entries zero, write dropped");

        // random mix
        for (int n = 0; n < 240; n++) begin
            int unsigned op;
            logic [7:0] a, d;
            op = $urandom % 8;
            case (op)
                0: wr(8'h04, 8'($urandom) & 8'h7B);
                1: wr(8'h05, 8'($urandom) & 8'h03);
                2: wr(8'h06, 8'($urandom));
                3, 4, 5: begin
                    d = (($urandom % 10) == 0) ? 8'hFF : 8'($urandom);
                    wr(8'h07, d);
                end
                6: begin
                    case ($urandom % 5)
                        0: a = 8'h04;
                        1: a = 8'h05;
                        2: a = 8'h06;
                        3: a = 8'h30;
                        default: a = 8'($urandom) & 8'h7F;
                    endcase
                    rd(a[6:0], "R3 R11 R12 random read");
                end
                default: begin
                    a = 8'($urandom) & 8'h7F;
                    if (a >= 8'h04 && a <= 8'h07) a = a + 8'h08;
                    wr(a, 8'($urandom) & 8'hFB);
                end
            endcase
            if ((n % 60) == 59) sweep("R6 R5 random memory compare");
        end
        sweep("R4 R6 final memory compare");
        summary();
    end

endmodule